// File: doc/BRIEF.md
# Double-Buffered Packet Receive Store

This block is the receive-side store for one bulk OUT endpoint. It has two packet slots. Each slot holds one maximum-size packet of `PKT_BYTES` bytes, so the default store is 128 bytes in two 64-byte slots. The USB side writes the bytes of an arriving packet into the free slot. It then ends the packet with either an accept strobe or a reject strobe. An accepted packet becomes visible to the reader together with its byte count. A rejected packet leaves no trace.

The reader can be a CPU or a DMA engine. It always sees the oldest accepted packet. It pulls bytes out one at a time through an 8-bit registered data port and reads the packet length from a size output. When it has finished, it hands the slot back with a release strobe. A ready flag and a DMA request tell the reader when there is data to take. A busy indication tells the USB side to NAK while both slots are occupied. A synchronous clear input empties the whole store.

Top module: `pp_rx_buffer`

## Requirements
- R1: After reset, `pkt_ready`, `nak`, `dma_req` and `rd_data` are 0 and `rx_count` is 0.
- R2: A byte presented with `wr_valid` is stored at the next position of the free slot, but only in a cycle with no `pkt_ok`, no `pkt_err`, no `clr` and `nak` low. A `pkt_ok` strobe accepts the packet. In the next cycle `pkt_ready` is high and `rx_count` equals the number of bytes stored. Zero-length packets are accepted.
- R3: A `pkt_err` strobe discards the bytes of the packet being written without raising `pkt_ready`. The next packet starts again at byte 0. If `pkt_err` and `pkt_ok` arrive in the same cycle, `pkt_err` wins.
- R4: Bytes beyond `PKT_BYTES` in one packet are ignored, so `rx_count` never exceeds `PKT_BYTES`.
- R5: While both slots hold unreleased packets, `nak` is high and `wr_valid` and `pkt_ok` have no effect.
- R6: A `rd_en` pulse while unread bytes remain loads the next byte of the oldest packet onto `rd_data` one cycle later. A `rd_en` pulse past the end of the packet, or while no packet is ready, leaves `rd_data` unchanged.
- R7: A `rd_done` pulse frees the oldest packet. In the next cycle `pkt_ready` and `rx_count` describe the other slot if it holds a packet, and otherwise read 0. A `rd_done` pulse with no packet ready is ignored.
- R8: `dma_req` is high exactly when a packet is ready and not all of its bytes have been read.
- R9: `clr` returns both slots to empty, zeroes all pointers and `rd_data`, and overrides every other input in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of the whole store |
| wr_valid | input | 1 | Incoming byte strobe from the USB side |
| wr_data | input | DATA_W | Incoming byte |
| pkt_ok | input | 1 | Accept the packet being written |
| pkt_err | input | 1 | Discard the packet being written |
| nak | output | 1 | Both slots occupied; refuse new data |
| rd_en | input | 1 | Fetch the next byte of the oldest packet |
| rd_done | input | 1 | Release the oldest packet's slot |
| rd_data | output | DATA_W | Last fetched byte (registered) |
| pkt_ready | output | 1 | An accepted packet awaits reading |
| rx_count | output | CNT_W | Byte count of the oldest packet, 0 if none (CNT_W = clog2(PKT_BYTES+1)) |
| dma_req | output | 1 | Unread bytes remain in the oldest packet |

## Verification
The bench builds the block with `PKT_BYTES` = 8 and `DATA_W` = 8. With 8-byte slots, overrunning a packet takes only a handful of cycles, and so does filling both slots into the NAK state. A long random phase can therefore pass through overflow, full-store, release-while-accepting and clear-during-read states many times. Every cycle, each output is compared with a behavioural model built from a queue of accepted packet lengths and a queue of their bytes.

// File: rtl/pprx_pkg.sv
package pprx_pkg;

  typedef enum logic [1:0] {
    EOP_NONE   = 2'd0,
    EOP_ACCEPT = 2'd1,
    EOP_DROP   = 2'd2
  } eop_e;

  // Reject beats accept when both strobes arrive together.
  function automatic eop_e decode_eop(input logic ok, input logic err);
    if (err)     return EOP_DROP;
    else if (ok) return EOP_ACCEPT;
    else         return EOP_NONE;
  endfunction

  // Storage address of a byte: slot 1 sits above slot 0.
  function automatic int unsigned slot_base(input logic half, input int unsigned depth);
    return half ? depth : 0;
  endfunction

endpackage

// File: rtl/pprx_fill_ctl.sv
module pprx_fill_ctl
  import pprx_pkg::*;
#(
  parameter int PKT_BYTES = 64,
  parameter int CNT_W     = $clog2(PKT_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_valid,
  input  logic             pkt_ok,
  input  logic             pkt_err,
  input  logic             blocked,
  output logic             wr_half,
  output logic [CNT_W-1:0] wr_ptr,
  output logic             store_en,
  output logic             commit_evt,
  output logic [CNT_W-1:0] commit_len
);

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(PKT_BYTES);

  eop_e eop;

  always_comb begin
    eop        = decode_eop(pkt_ok, pkt_err);
    store_en   = wr_valid && !blocked && !clr && (eop == EOP_NONE) && (wr_ptr < LIMIT);
    commit_evt = (eop == EOP_ACCEPT) && !blocked && !clr;
    commit_len = wr_ptr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      wr_half <= 1'b0;
    end else if (clr) begin
      wr_ptr  <= '0;
      wr_half <= 1'b0;
    end else if (eop == EOP_DROP) begin
      wr_ptr  <= '0;
    end else if (commit_evt) begin
      wr_ptr  <= '0;
      wr_half <= ~wr_half;
    end else if (store_en) begin
      wr_ptr  <= wr_ptr + 1'b1;
    end
  end

  // R4
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ptr <= LIMIT);

  // R5
  nak_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blocked && !clr) |=> ($stable(wr_ptr) && $stable(wr_half)));

  // R3
  drop_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_err && !clr) |=> (wr_ptr == '0 && $stable(wr_half)));

endmodule

// File: rtl/pprx_drain_ctl.sv
module pprx_drain_ctl #(
  parameter int PKT_BYTES = 64,
  parameter int CNT_W     = $clog2(PKT_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             rd_en,
  input  logic             rd_done,
  input  logic             cur_full,
  input  logic [CNT_W-1:0] cur_len,
  output logic             rd_half,
  output logic [CNT_W-1:0] rd_ptr,
  output logic             fetch_en,
  output logic             release_evt,
  output logic             bytes_left
);

  always_comb begin
    bytes_left  = cur_full && (rd_ptr < cur_len);
    fetch_en    = rd_en && bytes_left && !clr;
    release_evt = rd_done && cur_full && !clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr  <= '0;
      rd_half <= 1'b0;
    end else if (clr) begin
      rd_ptr  <= '0;
      rd_half <= 1'b0;
    end else if (release_evt) begin
      rd_ptr  <= '0;
      rd_half <= ~rd_half;
    end else if (fetch_en) begin
      rd_ptr  <= rd_ptr + 1'b1;
    end
  end

  // R6
  read_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur_full ? (rd_ptr <= cur_len) : (rd_ptr == '0));

  // R7
  release_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && !cur_full && !clr) |=> $stable(rd_half));

endmodule

// File: rtl/pprx_store.sv
module pprx_store
  import pprx_pkg::*;
#(
  parameter int PKT_BYTES = 64,
  parameter int DATA_W    = 8,
  parameter int CNT_W     = $clog2(PKT_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              we,
  input  logic              w_half,
  input  logic [CNT_W-1:0]  w_idx,
  input  logic [DATA_W-1:0] w_data,
  input  logic              re,
  input  logic              r_half,
  input  logic [CNT_W-1:0]  r_idx,
  output logic [DATA_W-1:0] r_data
);

  localparam int DEPTH  = 2 * PKT_BYTES;
  localparam int ADDR_W = $clog2(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] w_addr, r_addr;

  always_comb begin
    w_addr = ADDR_W'(slot_base(w_half, PKT_BYTES) + int'(w_idx));
    r_addr = ADDR_W'(slot_base(r_half, PKT_BYTES) + int'(r_idx));
  end

  always_ff @(posedge clk) begin
    if (we) mem[w_addr] <= w_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   r_data <= '0;
    else if (clr) r_data <= '0;
    else if (re)  r_data <= mem[r_addr];
  end

  // R6
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!re && !clr) |=> $stable(r_data));

endmodule

// File: rtl/pp_rx_buffer.sv
module pp_rx_buffer #(
  parameter int PKT_BYTES = 64,
  parameter int DATA_W    = 8,
  parameter int CNT_W     = $clog2(PKT_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pkt_ok,
  input  logic              pkt_err,
  output logic              nak,
  input  logic              rd_en,
  input  logic              rd_done,
  output logic [DATA_W-1:0] rd_data,
  output logic              pkt_ready,
  output logic [CNT_W-1:0]  rx_count,
  output logic              dma_req
);

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(PKT_BYTES);

  logic [1:0]       slot_full;
  logic [CNT_W-1:0] slot_len [2];

  logic             wr_half, rd_half;
  logic [CNT_W-1:0] wr_ptr, rd_ptr, commit_len;
  logic             store_en, commit_evt, fetch_en, release_evt, bytes_left;

  assign nak       = slot_full[wr_half];
  assign pkt_ready = slot_full[rd_half];
  assign rx_count  = pkt_ready ? slot_len[rd_half] : '0;
  assign dma_req   = bytes_left;

  pprx_fill_ctl #(.PKT_BYTES(PKT_BYTES), .CNT_W(CNT_W)) u_fill (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .wr_valid   (wr_valid),
    .pkt_ok     (pkt_ok),
    .pkt_err    (pkt_err),
    .blocked    (nak),
    .wr_half    (wr_half),
    .wr_ptr     (wr_ptr),
    .store_en   (store_en),
    .commit_evt (commit_evt),
    .commit_len (commit_len)
  );

  pprx_drain_ctl #(.PKT_BYTES(PKT_BYTES), .CNT_W(CNT_W)) u_drain (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (clr),
    .rd_en       (rd_en),
    .rd_done     (rd_done),
    .cur_full    (pkt_ready),
    .cur_len     (slot_len[rd_half]),
    .rd_half     (rd_half),
    .rd_ptr      (rd_ptr),
    .fetch_en    (fetch_en),
    .release_evt (release_evt),
    .bytes_left  (bytes_left)
  );

  pprx_store #(.PKT_BYTES(PKT_BYTES), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr),
    .we     (store_en),
    .w_half (wr_half),
    .w_idx  (wr_ptr),
    .w_data (wr_data),
    .re     (fetch_en),
    .r_half (rd_half),
    .r_idx  (rd_ptr),
    .r_data (rd_data)
  );

  // Slot occupancy: set on accept into the write slot, cleared on release of the read slot.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_full   <= '0;
      slot_len[0] <= '0;
      slot_len[1] <= '0;
    end else if (clr) begin
      slot_full   <= '0;
      slot_len[0] <= '0;
      slot_len[1] <= '0;
    end else begin
      if (release_evt) slot_full[rd_half] <= 1'b0;
      if (commit_evt) begin
        slot_full[wr_half] <= 1'b1;
        slot_len[wr_half]  <= commit_len;
      end
    end
  end

  // R2
  ready_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pkt_ready) |-> $past(commit_evt));

  // R7
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pkt_ready) |-> $past(release_evt || clr));

  // R8
  dma_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> (pkt_ready && rx_count != '0));

  // R5
  both_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nak |-> (slot_full == 2'b11 && wr_half == rd_half));

  // R4
  count_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= LIMIT);

  // R9
  clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!pkt_ready && !nak && rd_data == '0));

endmodule

// File: tb/sim_pp_rx_buffer.sv
`timescale 1ns/1ps
module sim_pp_rx_buffer;

  localparam int P  = 8;
  localparam int DW = 8;
  localparam int CW = $clog2(P + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 0, wr_valid = 0, pkt_ok = 0, pkt_err = 0, rd_en = 0, rd_done = 0;
  logic [DW-1:0] wr_data = '0;
  logic nak, pkt_ready, dma_req;
  logic [DW-1:0] rd_data;
  logic [CW-1:0] rx_count;

  always #4 clk = ~clk;

  pp_rx_buffer #(.PKT_BYTES(P), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .wr_valid(wr_valid), .wr_data(wr_data),
    .pkt_ok(pkt_ok), .pkt_err(pkt_err), .nak(nak), .rd_en(rd_en), .rd_done(rd_done),
    .rd_data(rd_data), .pkt_ready(pkt_ready), .rx_count(rx_count), .dma_req(dma_req)
  );

  // Behavioural model: queue of accepted lengths, queue of their bytes, bytes in flight.
  int            m_len[$];
  logic [DW-1:0] m_bytes[$];
  logic [DW-1:0] m_cur[$];
  int            m_rp;
  logic [DW-1:0] m_rd;

  int    n_vec = 0, n_bad = 0, n_cyc = 0;
  string tag = "R1";
  bit    done_flag = 0;

  task automatic model_reset();
    m_len.delete(); m_bytes.delete(); m_cur.delete(); m_rp = 0; m_rd = '0;
  endtask

  task automatic model_step();
    bit had, busy;
    if (clr) begin model_reset(); return; end
    had  = m_len.size() > 0;
    busy = m_len.size() == 2;
    if (rd_en && had && m_rp < m_len[0]) begin m_rd = m_bytes[m_rp]; m_rp++; end
    if (rd_done && had) begin
      for (int k = 0; k < m_len[0]; k++) void'(m_bytes.pop_front());
      void'(m_len.pop_front());
      m_rp = 0;
    end
    if (pkt_err) m_cur.delete();
    else if (pkt_ok) begin
      if (!busy) begin
        m_len.push_back(m_cur.size());
        foreach (m_cur[i]) m_bytes.push_back(m_cur[i]);
        m_cur.delete();
      end
    end else if (wr_valid && !busy && m_cur.size() < P) m_cur.push_back(wr_data);
  endtask

  task automatic chk(input string what, input int got, input int exp, input string rq);
    n_vec++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d (t=%0t)", rq, what, got, exp, $time);
    end
  endtask

  task automatic compare();
    bit f;
    int sz;
    f  = m_len.size() > 0;
    sz = f ? m_len[0] : 0;
    chk("pkt_ready", int'(pkt_ready), int'(f), tag == "R1" ? "R1" : "R2/R7");
    chk("rx_count",  int'(rx_count),  sz,      tag == "R4" ? "R4" : "R2/R7");
    chk("nak",       int'(nak),       int'(m_len.size() == 2), "R5");
    chk("dma_req",   int'(dma_req),   int'(f && m_rp < sz), "R8");
    chk("rd_data",   int'(rd_data),   int'(m_rd), tag == "R9" ? "R9" : "R6");
  endtask

  // One cycle: inputs are set at a falling edge, model follows the rising edge, outputs checked at the next falling edge.
  task automatic step(input bit wv, input logic [DW-1:0] wd, input bit ok, input bit er,
                      input bit re, input bit dn, input bit c);
    wr_valid = wv; wr_data = wd; pkt_ok = ok; pkt_err = er; rd_en = re; rd_done = dn; clr = c;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic idle();                                  step(0, '0, 0, 0, 0, 0, 0); endtask
  task automatic put(input logic [DW-1:0] b);             step(1, b, 0, 0, 0, 0, 0); endtask
  task automatic accept();                                step(0, '0, 1, 0, 0, 0, 0); endtask
  task automatic reject();                                step(0, '0, 0, 1, 0, 0, 0); endtask
  task automatic fetch();                                 step(0, '0, 0, 0, 1, 0, 0); endtask
  task automatic release_slot();                          step(0, '0, 0, 0, 0, 1, 0); endtask

  task automatic packet(input int n, input logic [DW-1:0] base);
    for (int i = 0; i < n; i++) put(base + DW'(i));
    accept();
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    n_cyc++;
    if (n_cyc > 150000 && !done_flag) begin
      done_flag = 1;
      n_bad++;
      $display("FAIL watchdog: got %0d cycles expected completion", n_cyc);
      finish_run();
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    tag = "R1"; compare();
    rst_n = 1'b1;
    @(negedge clk); compare();

    // R2 accept and R6 sequential fetch, R8 request until drained, R7 release
    tag = "R2";
    packet(5, 8'h10);
    for (int i = 0; i < 6; i++) fetch();   // R6 last pulse is past the end
    release_slot();
    tag = "R2"; packet(0, 8'h00);          // zero-length packet, R8 stays low
    release_slot();

    // R3 discard then a fresh packet from byte 0; error beats accept
    tag = "R3";
    put(8'hA0); put(8'hA1); put(8'hA2); reject();
    packet(4, 8'h40);
    fetch(); fetch();
    put(8'h77); step(0, '0, 1, 1, 0, 0, 0);   // R3 simultaneous strobes: dropped
    step(1, 8'h55, 1, 0, 0, 0, 0);           // R2 byte with accept is not stored
    release_slot(); fetch();

    // R4 overrun
    tag = "R4";
    packet(11, 8'h80);
    fetch(); release_slot();

    // R5 both slots full
    tag = "R5";
    packet(3, 8'h20); packet(6, 8'h30);
    put(8'hEE); put(8'hEF); accept();
    fetch(); release_slot();               // R7 moves to second packet
    fetch(); fetch();
    // R7 accept and release together
    put(8'h60); step(0, '0, 1, 0, 0, 1, 0);
    fetch(); release_slot(); release_slot(); release_slot();   // extra release ignored
    fetch();                                // R6 fetch with nothing ready

    // R9 clear in mid-read with both full and a packet in flight
    tag = "R9";
    packet(2, 8'h01); packet(7, 8'h02); fetch(); fetch();
    step(1, 8'h99, 1, 0, 1, 1, 1);
    idle(); packet(3, 8'hC0); fetch(); release_slot();

    // Mixed random traffic
    tag = "R2";
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      step(r < 45, DW'($urandom), (r >= 45 && r < 55), (r >= 55 && r < 58),
           ($urandom_range(0, 2) == 0), ($urandom_range(0, 9) == 0), (r == 99));
    end

    done_flag = 1;
    finish_run();
  end

endmodule